// File: doc/BRIEF.md
# Receiver-Detect Handshake Sequencer

This block is the MAC-side controller for the receiver-detect exchange with an off-chip PHY whose status line cannot return a clean single-cycle strobe. The link layer pulses a start request. The sequencer raises its detect command and keeps it high until the PHY's status line is seen high. It then lowers the command. The PHY holds status high until it has sampled that falling command edge. The return of status to low is taken as the PHY's acknowledgement, and the sequencer then reports completion.

The status input first passes through a flop synchronizer into the MAC clock domain. A single-cycle status pulse is derived from the synchronized level for downstream logic that was written for strobe-style signalling. Both wait phases are bounded by a run-time cycle limit. When a phase overruns that limit, the command is dropped and an error is reported.

Top module: `rxdet_handshake_seq`

## Requirements
- R1: While reset is asserted, cmd_o, done_o, err_o and status_pulse_o are all low, and asserting reset during a sequence lowers cmd_o at once.
- R2: status_pulse_o is high for exactly one cycle for each low-to-high change of phy_status_i, starting at the second rising clock edge after the input goes high.
- R3: A start_i sampled high while idle with synchronized status low raises cmd_o at that same clock edge.
- R4: cmd_o stays high until the synchronized status is seen high, and then falls at the next clock edge.
- R5: After cmd_o falls, done_o goes high for exactly one cycle once the synchronized status is seen low, and the block then returns to idle.
- R6: A start_i sampled while idle with synchronized status already high is refused: cmd_o stays low and err_o is high for one cycle.
- R7: If the synchronized status is not high after tmo_limit_i+1 cycles of waiting for it, cmd_o is forced low, err_o is high for one cycle, done_o is not raised, and the block returns to idle. A limit of 0 allows a single wait cycle.
- R8: If the synchronized status has not fallen after tmo_limit_i+1 cycles of waiting for it to go low, err_o is high for one cycle, done_o is not raised, and the block returns to idle.
- R9: start_i has no effect while a sequence is in progress.
- R10: done_o and err_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a receiver-detect sequence |
| phy_status_i | input | 1 | PHY status line, not yet synchronized |
| tmo_limit_i | input | TMO_W | Cycle limit for each wait phase |
| cmd_o | output | 1 | Registered detect command to the PHY |
| done_o | output | 1 | One-cycle completion flag |
| err_o | output | 1 | One-cycle refusal or timeout flag |
| status_pulse_o | output | 1 | One-cycle pulse on each rise of synchronized status |

## Verification
The bench drives a PHY model with a range of rise and fall delays. This covers a status that rises in the first cycle the command is high, a status that never rises, and a status that never falls. A design that waited for a one-cycle strobe would hang with the command stuck high. A design that counted the wrong cycles would time out one cycle early or one cycle late, which the zero-limit case exposes. A start while status is already high must be refused, so a design that ignored the level would raise the command against a busy PHY. A repeated start in mid-sequence and a reset in mid-sequence check that a design does not restart or leave the command high.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ASSERT  = 3'd1,
      ST_WAIT_HI = 3'd2,
      ST_DROP    = 3'd3,
      ST_WAIT_LO = 3'd4,
      ST_DONE    = 3'd5
   } rxdet_state_e;
endpackage

// File: rtl/rxdet_status_sync.sv
module rxdet_status_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic status_async_i,
   output logic status_o,
   output logic pulse_o
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rxdet_status_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= status_async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign status_o = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= status_o;
   end

   assign pulse_o = status_o & ~last_q;

   // R2
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/rxdet_wait_timer.sv
module rxdet_wait_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic [W-1:0] limit_i,
   output logic         expired_o
);
   logic [W-1:0] cnt;

   generate
      if (W < 1 || W > 32) begin : g_bad_width
         $error("rxdet_wait_timer: W must lie in 1..32");
      end
   endgenerate

   assign expired_o = run_i && (cnt >= limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run_i)     cnt <= '0;
      else if (!expired_o) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rxdet_ctrl.sv
module rxdet_ctrl
   import rxdet_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic status_i,
   input  logic expired_i,
   output logic run_o,
   output logic cmd_o,
   output logic done_o,
   output logic err_o
);
   rxdet_state_e state, state_n;
   logic         cmd_n, err_n;

   always_comb begin
      state_n = state;
      cmd_n   = cmd_o;
      err_n   = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start_i) begin
               if (status_i) begin
                  err_n = 1'b1;
               end else begin
                  state_n = ST_ASSERT;
                  cmd_n   = 1'b1;
               end
            end
         end
         ST_ASSERT:  state_n = ST_WAIT_HI;
         ST_WAIT_HI: begin
            if (status_i) begin
               state_n = ST_DROP;
               cmd_n   = 1'b0;
            end else if (expired_i) begin
               state_n = ST_IDLE;
               cmd_n   = 1'b0;
               err_n   = 1'b1;
            end
         end
         ST_DROP:    state_n = ST_WAIT_LO;
         ST_WAIT_LO: begin
            if (!status_i) begin
               state_n = ST_DONE;
            end else if (expired_i) begin
               state_n = ST_IDLE;
               err_n   = 1'b1;
            end
         end
         ST_DONE:    state_n = ST_IDLE;
         default: begin
            state_n = ST_IDLE;
            cmd_n   = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cmd_o <= 1'b0;
         err_o <= 1'b0;
      end else begin
         state <= state_n;
         cmd_o <= cmd_n;
         err_o <= err_n;
      end
   end

   assign done_o = (state == ST_DONE);
   assign run_o  = (state == ST_WAIT_HI) || (state == ST_WAIT_LO);

   // R10
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
   // R5
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R5
   done_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_LO && !status_i) |=> done_o);
   // R3
   cmd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start_i && !status_i) |=> cmd_o);
   // R6
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start_i && status_i) |=> (err_o && !cmd_o));
   // R4
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o && !status_i && !expired_i) |=> cmd_o);
   // R7
   tmo_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_HI && !status_i && expired_i) |=> (err_o && !cmd_o && state == ST_IDLE));
   // R8
   tmo_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_LO && status_i && expired_i) |=> (err_o && !done_o && state == ST_IDLE));
endmodule

// File: rtl/rxdet_handshake_seq.sv
module rxdet_handshake_seq #(
   parameter int SYNC_STAGES = 2,
   parameter int TMO_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             phy_status_i,
   input  logic [TMO_W-1:0] tmo_limit_i,
   output logic             cmd_o,
   output logic             done_o,
   output logic             err_o,
   output logic             status_pulse_o
);
   logic status_sync, run, expired;

   rxdet_status_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk            (clk),
      .rst_n          (rst_n),
      .status_async_i (phy_status_i),
      .status_o       (status_sync),
      .pulse_o        (status_pulse_o)
   );

   rxdet_wait_timer #(.W(TMO_W)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .limit_i   (tmo_limit_i),
      .expired_o (expired)
   );

   rxdet_ctrl i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .status_i  (status_sync),
      .expired_i (expired),
      .run_o     (run),
      .cmd_o     (cmd_o),
      .done_o    (done_o),
      .err_o     (err_o)
   );
endmodule

// File: tb/test_rxdet_handshake_seq.sv
module test_rxdet_handshake_seq;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic        phy_status;
   logic [15:0] limit;
   logic        cmd_o, done_o, err_o, pulse_o;

   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   rxdet_handshake_seq i_rxdet_handshake_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .phy_status_i(phy_status),
      .tmo_limit_i(limit), .cmd_o(cmd_o), .done_o(done_o), .err_o(err_o),
      .status_pulse_o(pulse_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 idle,1 assert,2 wait hi,3 drop,4 wait lo,5 done
   int m_state, m_cnt;
   bit m_cmd, m_err, m_p0, m_p1, m_last;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_cmd = 0; m_err = 0;
         m_p0 = 0; m_p1 = 0; m_last = 0;
      end else begin
         int ns; int nc; bit ncmd; bit nerr;
         ns = m_state; nc = m_cnt; ncmd = m_cmd; nerr = 0;
         case (m_state)
            0: if (start) begin
                  if (m_p1) nerr = 1;
                  else begin ns = 1; ncmd = 1; end
               end
            1: begin ns = 2; nc = 0; end
            2: if (m_p1) begin ns = 3; ncmd = 0; nc = 0; end
               else if (m_cnt >= int'(limit)) begin ns = 0; ncmd = 0; nerr = 1; nc = 0; end
               else nc = m_cnt + 1;
            3: begin ns = 4; nc = 0; end
            4: if (!m_p1) ns = 5;
               else if (m_cnt >= int'(limit)) begin ns = 0; nerr = 1; nc = 0; end
               else nc = m_cnt + 1;
            default: ns = 0;
         endcase
         m_state = ns; m_cnt = nc; m_cmd = ncmd; m_err = nerr;
         m_last = m_p1; m_p1 = m_p0; m_p0 = phy_status;
      end
   end

   // per-cycle comparison and event counting
   int done_cnt, err_cnt, pulse_cnt, rise_cnt;
   bit prev_cmd;
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cmd_o == m_cmd, "R4 cmd_o", cmd_o, m_cmd);
         chk(done_o == (m_state == 5), "R5 done_o", done_o, m_state == 5);
         chk(err_o == m_err, "R7 err_o", err_o, m_err);
         chk(pulse_o == (m_p1 && !m_last), "R2 status_pulse_o", pulse_o, m_p1 && !m_last);
         chk(!(done_o && err_o), "R10 done/err exclusive", done_o && err_o, 0);
         if (done_o) done_cnt++;
         if (err_o) err_cnt++;
         if (pulse_o) pulse_cnt++;
         if (cmd_o && !prev_cmd) rise_cnt++;
      end
      prev_cmd = cmd_o;
   end

   // PHY model
   bit phy_auto = 0;
   int rise_dly, fall_dly, hi_cnt, lo_cnt;
   always @(negedge clk) begin
      if (phy_auto) begin
         if (!phy_status) begin
            lo_cnt = 0;
            if (cmd_o) begin
               if (rise_dly >= 0 && hi_cnt >= rise_dly) phy_status = 1'b1;
               hi_cnt++;
            end else hi_cnt = 0;
         end else if (!cmd_o) begin
            lo_cnt++;
            if (fall_dly >= 0 && lo_cnt >= fall_dly) begin
               phy_status = 1'b0; hi_cnt = 0; lo_cnt = 0;
            end
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr();
      done_cnt = 0; err_cnt = 0; pulse_cnt = 0; rise_cnt = 0;
   endtask

   task automatic kick();
      start = 1'b1; cyc(1); start = 1'b0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; phy_status = 1'b0; limit = 16'd20;
      cyc(3);
      // R1 reset state
      chk(!cmd_o && !done_o && !err_o && !pulse_o, "R1 reset outputs",
          {cmd_o, done_o, err_o, pulse_o}, 0);
      rst_n = 1'b1;
      cyc(3);

      // normal sequence, R3 cmd rises at the sampling edge
      phy_auto = 1; rise_dly = 3; fall_dly = 2; clr();
      kick();
      chk(cmd_o == 1'b1, "R3 cmd after start", cmd_o, 1);
      cyc(30);
      chk(done_cnt == 1, "R5 one done", done_cnt, 1);
      chk(err_cnt == 0, "R5 no error", err_cnt, 0);
      chk(pulse_cnt == 1, "R2 one pulse", pulse_cnt, 1);

      // immediate status rise, slow fall
      rise_dly = 0; fall_dly = 5; clr();
      kick(); cyc(30);
      chk(done_cnt == 1, "R5 done fast rise", done_cnt, 1);
      chk(cmd_o == 1'b0, "R4 cmd low at end", cmd_o, 0);

      // R9 start repeated mid-sequence
      rise_dly = 8; fall_dly = 4; clr();
      kick(); cyc(4); kick(); cyc(40);
      chk(done_cnt == 1, "R9 single done", done_cnt, 1);
      chk(rise_cnt == 1, "R9 single cmd rise", rise_cnt, 1);

      // R7 status never rises
      limit = 16'd6; rise_dly = -1; clr();
      kick(); cyc(20);
      chk(err_cnt == 1, "R7 timeout error", err_cnt, 1);
      chk(done_cnt == 0, "R7 no done", done_cnt, 0);
      chk(cmd_o == 1'b0, "R7 cmd forced low", cmd_o, 0);

      // R7 zero limit boundary
      limit = 16'd0; rise_dly = 0; fall_dly = 1; clr();
      kick(); cyc(20);
      chk(err_cnt == 1, "R7 zero limit error", err_cnt, 1);
      chk(done_cnt == 0, "R7 zero limit no done", done_cnt, 0);
      phy_auto = 0; phy_status = 1'b0; cyc(5); phy_auto = 1; hi_cnt = 0; lo_cnt = 0;

      // R8 status never falls
      limit = 16'd6; rise_dly = 2; fall_dly = -1; clr();
      kick(); cyc(30);
      chk(err_cnt == 1, "R8 timeout error", err_cnt, 1);
      chk(done_cnt == 0, "R8 no done", done_cnt, 0);

      // R6 refused while status still high
      clr();
      kick(); cyc(5);
      chk(err_cnt == 1, "R6 refusal error", err_cnt, 1);
      chk(rise_cnt == 0, "R6 cmd stays low", rise_cnt, 0);

      // R2 manual toggle
      phy_auto = 0; phy_status = 1'b0; cyc(5); clr();
      phy_status = 1'b1; cyc(1);
      chk(pulse_o == 1'b0, "R2 no pulse after one edge", pulse_o, 0);
      cyc(1);
      chk(pulse_o == 1'b1, "R2 pulse after two edges", pulse_o, 1);
      cyc(3); phy_status = 1'b0; cyc(4);
      chk(pulse_cnt == 1, "R2 pulse count", pulse_cnt, 1);

      // R1 reset mid-sequence
      limit = 16'd20; phy_auto = 1; hi_cnt = 0; lo_cnt = 0; rise_dly = -1;
      kick(); cyc(3);
      rst_n = 1'b0; #1;
      chk(cmd_o == 1'b0, "R1 async reset drops cmd", cmd_o, 0);
      phy_auto = 0; phy_status = 1'b0;
      cyc(2); rst_n = 1'b1; cyc(3);

      finish_run();
   end
endmodule